// File: doc/BRIEF.md
# Transmit Word Packer and Serial Shifter

This block takes 36-bit output words from a host bus and turns each one into a 32-bit serial transmit word. Two 16-bit half-words are taken from the upper 32 bits of the host word. In byte mode, the two bytes within each half-word trade places, so a host that packs octets can write in its natural order. The four lowest host bits are never used. When the host has flagged the coming word as the final address word of a message, the second half-word is replaced by the station's own number, which arrives on a static input.

The packed word loads a 32-bit shift register. The register sends one bit, most significant first, on each cycle in which the serial tick enable is high. A one-cycle word-end strobe marks the point where the register is free again. The check word that closes a message is loaded through a separate 16-bit write. That write shortens the word to 16 bits, so the word-end strobe then follows 16 ticks instead of 32. Any write that reaches the block while it is still shifting is discarded and sets a sticky overrun flag.

A small state machine controls the block. It has three states:
- `ST_IDLE`: the register is empty.
- `ST_DATA`: a 32-bit word is being sent.
- `ST_CRC`: a 16-bit check word is being sent.

It has four transitions:
- `ST_IDLE` goes to `ST_DATA` on an accepted host write.
- `ST_IDLE` goes to `ST_CRC` on an accepted check write.
- `ST_DATA` goes back to `ST_IDLE` on the 32nd tick.
- `ST_CRC` goes back to `ST_IDLE` on the 16th tick.

Top module: `tx_word_shifter`

## Requirements
- R1: After reset, `busy`, `word_end`, `overrun`, `last_pending` and `ser_out` are all 0.
- R2: In half-word mode (`byte_mode`=0), the transmitted word is host bits 35:20 followed by host bits 19:4. Host bits 3:0 have no effect.
- R3: In byte mode (`byte_mode`=1), the first half-word is {bits 27:20, bits 35:28} and the second is {bits 11:4, bits 19:12}. Each is written high byte first. Host bits 3:0 have no effect.
- R4: When `last_pending` is 1 at the accepting write, the second half-word is `station_id`. The first half-word still follows the mode.
- R5: A `mark_last` pulse sets `last_pending`. An accepted host write clears it. A host write that is dropped leaves it unchanged. A `mark_last` in the same cycle as an accepted write leaves it set, and the current word is built with the value held before that cycle.
- R6: While busy, `ser_out` shows the current bit, most significant first. It advances only in cycles with `bit_tick`=1 and holds otherwise. `ser_out` is 0 when idle.
- R7: `word_end` is high for exactly one cycle, in the cycle after the 32nd tick of a data word. `busy` is 0 in that same cycle.
- R8: `crc_wr` in idle loads `crc_word`. It is sent most significant bit first, and `word_end` follows the 16th tick.
- R9: A host or check write while busy is dropped and sets `overrun`, which stays set until reset. The word in progress is sent unchanged.
- R10: If `host_wr` and `crc_wr` arrive together in idle, the host word is loaded and sent as a 32-bit word, the check write is dropped, and `overrun` is set.
- R11: A write is accepted only while `busy` is 0, and `busy` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Serial clock enable, one bit per high cycle |
| host_wr | input | 1 | Host data write strobe |
| host_word | input | 36 | Host data word |
| byte_mode | input | 1 | 0 = half-word order, 1 = byte order |
| mark_last | input | 1 | Flags the next host write as the address word |
| station_id | input | 16 | Local station number (static) |
| crc_wr | input | 1 | Check-word write strobe |
| crc_word | input | 16 | Check word value |
| ser_out | output | 1 | Serial data, most significant bit first |
| busy | output | 1 | Shift register occupied |
| word_end | output | 1 | One-cycle strobe: register free again |
| last_pending | output | 1 | Address-word flag is armed |
| overrun | output | 1 | Sticky: a write was dropped |

## Verification
Two pairs of functions can land on the same cycle.

The first pair is an accepting host write and a fresh `mark_last` pulse. The bench raises both together. It then judges that the word was built with the old flag value and that the flag stays armed for the next word, whose second half must then carry `station_id`.

The second pair is a write colliding with the busy shifter, or two writes colliding in idle. The bench issues the colliding write between ticks, and issues `host_wr` together with `crc_wr` in idle. It requires the serial stream of the word in progress to match the arithmetic expectation bit for bit, requires `overrun` to rise, and requires `word_end` to follow the 32-tick count, not the 16-tick count.

// File: rtl/tx_shift_pkg.sv
package tx_shift_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CRC  = 2'd2
    } tx_state_t;
endpackage

// File: rtl/tx_packer.sv
module tx_packer #(
    parameter int HOST_W = 36,
    parameter int HALF_W = 16
) (
    input  logic [HOST_W-1:0]   host_word,
    input  logic                byte_mode,
    input  logic                use_station,
    input  logic [HALF_W-1:0]   station_id,
    output logic [2*HALF_W-1:0] packed_word
);
    localparam int BYTE_W = HALF_W / 2;
    localparam int TOP    = HOST_W - 1;

    logic [HALF_W-1:0] first_raw, second_raw;
    logic [HALF_W-1:0] first_half, second_half;

    assign first_raw  = host_word[TOP -: HALF_W];
    assign second_raw = host_word[TOP-HALF_W -: HALF_W];

    always_comb begin
        if (byte_mode) begin
            first_half  = {first_raw[BYTE_W-1:0],  first_raw[HALF_W-1:BYTE_W]};
            second_half = {second_raw[BYTE_W-1:0], second_raw[HALF_W-1:BYTE_W]};
        end else begin
            first_half  = first_raw;
            second_half = second_raw;
        end
        if (use_station) begin
            second_half = station_id;
        end
    end

    assign packed_word = {first_half, second_half};
endmodule

// File: rtl/tx_last_flag.sv
module tx_last_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic consume,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (arm) begin
            armed <= 1'b1;
        end else if (consume) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_shift_core.sv
module tx_shift_core
    import tx_shift_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load_data,
    input  logic              load_crc,
    input  logic [WORD_W-1:0] data_word,
    input  logic [CRC_W-1:0]  crc_word,
    output logic              ser_out,
    output logic              busy,
    output logic              word_end
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int PAD_W = WORD_W - CRC_W;

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              last_bit;

    assign last_bit = bit_tick && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_data) begin
                    state_d = ST_DATA;
                end else if (load_crc) begin
                    state_d = ST_CRC;
                end
            end
            ST_DATA, ST_CRC: begin
                if (last_bit) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            left_q   <= '0;
            word_end <= 1'b0;
        end else begin
            word_end <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load_data) begin
                        shreg_q <= data_word;
                        left_q  <= CNT_W'(WORD_W);
                    end else if (load_crc) begin
                        shreg_q <= {crc_word, {PAD_W{1'b0}}};
                        left_q  <= CNT_W'(CRC_W);
                    end
                end
                ST_DATA, ST_CRC: begin
                    if (bit_tick) begin
                        shreg_q  <= {shreg_q[WORD_W-2:0], 1'b0};
                        left_q   <= left_q - CNT_W'(1);
                        word_end <= last_bit;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign ser_out = busy & shreg_q[WORD_W-1];
endmodule

// File: rtl/tx_word_shifter.sv
module tx_word_shifter #(
    parameter int HOST_W = 36,
    parameter int HALF_W = 16,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_word,
    input  logic              byte_mode,
    input  logic              mark_last,
    input  logic [HALF_W-1:0] station_id,
    input  logic              crc_wr,
    input  logic [CRC_W-1:0]  crc_word,
    output logic              ser_out,
    output logic              busy,
    output logic              word_end,
    output logic              last_pending,
    output logic              overrun
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int SPARE_W = HOST_W - WORD_W;

    logic [WORD_W-1:0] packed_word;
    logic              take_data, take_crc, drop_any;
    logic              unused_spare;

    assign unused_spare = ^host_word[SPARE_W-1:0];

    assign take_data = host_wr && !busy;
    assign take_crc  = crc_wr && !busy && !host_wr;
    assign drop_any  = ((host_wr || crc_wr) && busy) || (host_wr && crc_wr);

    tx_packer #(.HOST_W(HOST_W), .HALF_W(HALF_W)) u_packer (
        .host_word   (host_word),
        .byte_mode   (byte_mode),
        .use_station (last_pending),
        .station_id  (station_id),
        .packed_word (packed_word)
    );

    tx_last_flag u_last (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (mark_last),
        .consume (take_data),
        .armed   (last_pending)
    );

    tx_shift_core #(.WORD_W(WORD_W), .CRC_W(CRC_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .load_data (take_data),
        .load_crc  (take_crc),
        .data_word (packed_word),
        .crc_word  (crc_word),
        .ser_out   (ser_out),
        .busy      (busy),
        .word_end  (word_end)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop_any) begin
            overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/tx_word_shifter_chk.sv
module tx_word_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic host_wr,
    input logic crc_wr,
    input logic mark_last,
    input logic ser_out,
    input logic busy,
    input logic word_end,
    input logic last_pending,
    input logic overrun
);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_out);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(ser_out));
    assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |-> !busy);
    assert_end_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> !word_end);
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || crc_wr) && busy) |=> overrun);
    assert_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && crc_wr) |=> (overrun && busy));
    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || crc_wr) && !busy) |=> busy);
    assert_last_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy && !mark_last) |=> !last_pending);
    assert_last_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pending && busy) |=> last_pending);
endmodule

bind tx_word_shifter tx_word_shifter_chk u_chk (.*);

// File: tb/tb_tx_word_shifter.sv
module tb_tx_word_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        host_wr = 1'b0;
    logic [35:0] host_word = '0;
    logic        byte_mode = 1'b0;
    logic        mark_last = 1'b0;
    logic [15:0] station_id = 16'hA5C3;
    logic        crc_wr = 1'b0;
    logic [15:0] crc_word = '0;
    logic        ser_out, busy, word_end, last_pending, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tx_word_shifter dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [35:0] d, input bit bm,
                                                input bit lst, input logic [15:0] st);
        logic [15:0] a, b;
        a = d[35:20];
        b = d[19:4];
        if (bm) begin
            a = {d[27:20], d[35:28]};
            b = {d[11:4], d[19:12]};
        end
        if (lst) b = st;
        return {a, b};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_word(input logic [35:0] d, input bit bm, input bit mk);
        @(negedge clk);
        host_word = d;
        byte_mode = bm;
        host_wr   = 1'b1;
        mark_last = mk;
        @(negedge clk);
        host_wr   = 1'b0;
        mark_last = 1'b0;
    endtask

    task automatic pulse_mark();
        @(negedge clk);
        mark_last = 1'b1;
        @(negedge clk);
        mark_last = 1'b0;
    endtask

    // Shifts n bits out, collecting ser_out before each tick, then checks word_end timing
    task automatic run_bits(input int n, input bit gap, output logic [31:0] got,
                            output bit hold_ok, output bit end_ok);
        logic prev;
        got = '0;
        hold_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            got = {got[30:0], ser_out};
            if (gap) begin
                prev = ser_out;
                @(negedge clk);
                if (ser_out !== prev || word_end !== 1'b0) hold_ok = 1'b0;
            end
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            if (i < n - 1 && (word_end !== 1'b0 || busy !== 1'b1)) hold_ok = 1'b0;
        end
        end_ok = (word_end === 1'b1) && (busy === 1'b0) && (ser_out === 1'b0);
        @(negedge clk);
        if (word_end !== 1'b0) end_ok = 1'b0;
    endtask

    initial begin
        logic [31:0] got, expw;
        bit hold_ok, end_ok;
        logic [35:0] d;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 0 && word_end === 0 && overrun === 0 && last_pending === 0 && ser_out === 0,
              "R1", {27'd0, busy, word_end, overrun, last_pending, ser_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && ser_out === 0, "R1", {30'd0, busy, ser_out}, 32'd0);

        // Sweep: mode x last flag x patterns x tick spacing (R2, R3, R4, R6, R7, R11)
        for (int bm = 0; bm < 2; bm++) begin
            for (int lst = 0; lst < 2; lst++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int gp = 0; gp < 2; gp++) begin
                        d = (k == 0) ? 36'hF_FFFF_FFFF :
                            36'(64'(k) * 64'h0_9E37_79B9 ^ 64'(k * 5));
                        station_id = 16'h1357 + 16'(k * 257);
                        if (lst != 0) pulse_mark();
                        write_word(d, bm[0], 1'b0);
                        // R11: busy in the cycle after accept
                        check(busy === 1'b1, "R11", {31'd0, busy}, 32'd1);
                        check(last_pending === 1'b0, "R5", {31'd0, last_pending}, 32'd0);
                        run_bits(32, gp[0], got, hold_ok, end_ok);
                        expw = expect_word(d, bm[0], lst[0], station_id);
                        if (lst != 0) check(got === expw, "R4", got, expw);
                        else if (bm != 0) check(got === expw, "R3", got, expw);
                        else check(got === expw, "R2", got, expw);
                        check(hold_ok, "R6", {31'd0, hold_ok}, 32'd1);
                        check(end_ok, "R7", {31'd0, end_ok}, 32'd1);
                    end
                end
            end
        end

        // R2/R3: low bits 3:0 ignored (same upper bits, different spare bits)
        write_word(36'h1234_5678_F, 1'b1, 1'b0);
        run_bits(32, 1'b0, got, hold_ok, end_ok);
        expw = expect_word(36'h1234_5678_0, 1'b1, 1'b0, station_id);
        check(got === expw, "R3", got, expw);

        // R8: check word shifted in 16 ticks
        @(negedge clk);
        crc_word = 16'hC0DE;
        crc_wr = 1'b1;
        @(negedge clk);
        crc_wr = 1'b0;
        check(busy === 1'b1, "R11", {31'd0, busy}, 32'd1);
        run_bits(16, 1'b0, got, hold_ok, end_ok);
        check(got[15:0] === 16'hC0DE, "R8", {16'd0, got[15:0]}, 32'h0000C0DE);
        check(end_ok && hold_ok, "R8", {30'd0, hold_ok, end_ok}, 32'd3);

        // R5: mark_last together with an accepted write
        write_word(36'hABCD_1234_0, 1'b0, 1'b1);
        check(last_pending === 1'b1, "R5", {31'd0, last_pending}, 32'd1);
        run_bits(32, 1'b0, got, hold_ok, end_ok);
        expw = expect_word(36'hABCD_1234_0, 1'b0, 1'b0, station_id);
        check(got === expw, "R5", got, expw);
        write_word(36'h5555_AAAA_0, 1'b0, 1'b0);
        run_bits(32, 1'b0, got, hold_ok, end_ok);
        expw = expect_word(36'h5555_AAAA_0, 1'b0, 1'b1, station_id);
        check(got === expw, "R5", got, expw);
        check(last_pending === 1'b0, "R5", {31'd0, last_pending}, 32'd0);
        check(overrun === 1'b0, "R9", {31'd0, overrun}, 32'd0);

        // R9: write while busy is dropped, sticky overrun, flag kept
        write_word(36'h0F0F_3C3C_0, 1'b1, 1'b0);
        write_word(36'hFFFF_FFFF_F, 1'b0, 1'b1);
        check(overrun === 1'b1, "R9", {31'd0, overrun}, 32'd1);
        check(last_pending === 1'b1, "R5", {31'd0, last_pending}, 32'd1);
        @(negedge clk);
        crc_wr = 1'b1;
        @(negedge clk);
        crc_wr = 1'b0;
        run_bits(32, 1'b0, got, hold_ok, end_ok);
        expw = expect_word(36'h0F0F_3C3C_0, 1'b1, 1'b0, station_id);
        check(got === expw, "R9", got, expw);
        check(end_ok && overrun === 1'b1, "R9", {30'd0, end_ok, overrun}, 32'd3);
        write_word(36'h2468_ACE0_0, 1'b0, 1'b0);
        run_bits(32, 1'b0, got, hold_ok, end_ok);
        expw = expect_word(36'h2468_ACE0_0, 1'b0, 1'b1, station_id);
        check(got === expw, "R5", got, expw);

        // R10: simultaneous host and check writes in idle
        do_reset();
        check(overrun === 1'b0, "R1", {31'd0, overrun}, 32'd0);
        @(negedge clk);
        host_word = 36'h8001_7FFE_0;
        byte_mode = 1'b0;
        crc_word = 16'hFFFF;
        host_wr = 1'b1;
        crc_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        crc_wr = 1'b0;
        check(overrun === 1'b1 && busy === 1'b1, "R10", {30'd0, overrun, busy}, 32'd3);
        run_bits(32, 1'b0, got, hold_ok, end_ok);
        expw = expect_word(36'h8001_7FFE_0, 1'b0, 1'b0, station_id);
        check(got === expw, "R10", got, expw);
        check(end_ok && hold_ok, "R10", {30'd0, hold_ok, end_ok}, 32'd3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule